// File: doc/BRIEF.md
# Shift-Register Upset Test Harness

This block is a self-checking structure for measuring how often flip-flops lose their stored value. A pattern source produces a bit that changes value on every clock cycle. That bit feeds a chain of `STAGES` rising-edge flip-flops. Between each pair of neighbouring stages sits a configurable number of inverters, and that number must be even, so each gap acts as a logical pass-through with added path length. A checker at the end of the chain knows the chain latency. It compares the chain output with the alternating reference it expects, and it counts every cycle in which the two disagree.

A run begins with a one-cycle `start` pulse. That pulse clears all results and restarts the pattern phase and the cycle index. For the first `STAGES` cycles the chain still holds old contents, so the checker ignores the output during that time. Three results are reported: a saturating mismatch count, a sticky flag, and the cycle index of the first mismatch. A test-only injection port can invert the bit that any single stage captures at a clock edge. This lets the detection path be exercised without a beam. The same harness is meant to be run at several clock frequencies and gap sizes so that the counts can be compared.

Top module: `sr_upset_harness`

## Requirements
- R1: While `rst_n` is low, and after it rises, `err_count`, `err_flag` and `first_err_idx` read 0. Reset also clears every chain stage, the pattern bit and the cycle index.
- R2: With no injection, the chain output always matches the expected pattern and `err_count` stays 0. This holds for any even `INV_PER_GAP` (an odd value is rejected at elaboration) and for both odd and even `STAGES`.
- R3: The cycle index is 0 after the start edge and counts up by one per clock. The pattern bit at cycle index c is c mod 2. The output is compared only at edges where the cycle index is at least `STAGES`; before that a mismatch is ignored.
- R4: When `upset_en` is high at an edge, stage `upset_sel` (0 is nearest the source, `STAGES-1` drives the checker) captures the inverse of its normal input. A single such flip causes exactly one counted mismatch, provided it reaches the checker after the ignore window. The count grows by at most 1 per cycle.
- R5: `first_err_idx` holds the cycle index of the edge at which the first mismatch of a run is counted. It stays fixed for later mismatches in the same run. A flip of stage k at an edge whose cycle index before the edge is c gives the value c+STAGES-k, and is counted only if c >= k.
- R6: `err_flag` rises together with the first counted mismatch and stays high until reset or `start`; it is high exactly when `err_count` is nonzero.
- R7: `err_count` is `CNT_W` bits wide (default 16). It stops at its all-ones value (65535) and does not wrap.
- R8: A `start` pulse clears `err_count`, `err_flag` and `first_err_idx` at that edge, sets the cycle index to 0 and sets the pattern bit to 0; it takes priority over a mismatch at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run and clears results |
| upset_en | input | 1 | Test-only: invert the captured bit of one stage this edge |
| upset_sel | input | SEL_W | Test-only: index of the stage to invert |
| err_count | output | CNT_W | Saturating count of mismatching cycles |
| err_flag | output | 1 | Sticky flag, set by the first mismatch |
| first_err_idx | output | IDX_W | Cycle index of the first mismatch |

## Verification
The properties assume that `rst_n` is asserted once before any activity. They also assume that `start` is the only way a run is restarted, so a drop in the count is legal only at a start edge. The ignore-window property follows its own cycle count from the most recent `start`. For that reason the stimulus always begins each run with a clean one-cycle `start` pulse and keeps `upset_sel` inside the chain. The directed injections are placed on both sides of the c >= k boundary to cover both outcomes. The saturation run holds injection on the last stage continuously, so that exactly one mismatch is produced per cycle.

// File: rtl/sr_upset_harness.sv
module sr_upset_harness #(
  parameter int STAGES      = 16,
  parameter int INV_PER_GAP = 8,
  parameter int CNT_W       = 16,
  parameter int IDX_W       = 32,
  localparam int SEL_W      = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             upset_en,
  input  logic [SEL_W-1:0] upset_sel,
  output logic [CNT_W-1:0] err_count,
  output logic             err_flag,
  output logic [IDX_W-1:0] first_err_idx
);

  localparam bit LAT_ODD = (STAGES % 2) != 0;

  if (INV_PER_GAP % 2 != 0) begin : g_bad_gap
    $error("INV_PER_GAP must be even");
  end

  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] flip;
  logic              pat;
  logic              running;
  logic [IDX_W-1:0]  cyc;
  logic              check_en;
  logic              mismatch;

  assign chain_d[0] = pat;

  for (genvar g = 1; g < STAGES; g++) begin : g_gap
    logic [INV_PER_GAP:0] w;
    assign w[0] = chain[g-1];
    for (genvar i = 0; i < INV_PER_GAP; i++) begin : g_inv
      assign w[i+1] = ~w[i];
    end
    assign chain_d[g] = w[INV_PER_GAP];
  end

  assign flip = upset_en ? (STAGES'(1) << upset_sel) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chain <= '0;
    else        chain <= chain_d ^ flip;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pat     <= 1'b0;
      running <= 1'b0;
      cyc     <= '0;
    end else if (start) begin
      pat     <= 1'b0;
      running <= 1'b1;
      cyc     <= '0;
    end else if (running) begin
      pat <= ~pat;
      if (cyc != '1) cyc <= cyc + 1'b1;
    end

  assign check_en = running && !start && (cyc >= IDX_W'(STAGES));
  assign mismatch = check_en && (chain[STAGES-1] != (cyc[0] ^ LAT_ODD));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         err_count <= '0;
    else if (start)                     err_count <= '0;
    else if (mismatch && err_count != '1) err_count <= err_count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_flag      <= 1'b0;
      first_err_idx <= '0;
    end else if (start) begin
      err_flag      <= 1'b0;
      first_err_idx <= '0;
    end else if (mismatch && !err_flag) begin
      err_flag      <= 1'b1;
      first_err_idx <= cyc;
    end

endmodule

// File: rtl/sr_upset_harness_chk.sv
module sr_upset_harness_chk #(
  parameter int STAGES = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] err_count,
  input logic             err_flag,
  input logic [IDX_W-1:0] first_err_idx
);

  logic        seen;
  logic [31:0] wcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen <= 1'b0;
      wcnt <= '0;
    end else if (start) begin
      seen <= 1'b1;
      wcnt <= '0;
    end else if (wcnt < 32'(STAGES)) begin
      wcnt <= wcnt + 1;
    end

  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (err_count == '0 && !err_flag && first_err_idx == '0));  // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (err_count >= $past(err_count) && (err_count - $past(err_count)) <= 1));  // R4
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag == (err_count != '0));  // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !start) |=> err_flag);  // R6
  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !start) |=> $stable(first_err_idx));  // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == '1 && !start) |=> err_count == '1);  // R7
  AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !start && wcnt < 32'(STAGES)) |=> $stable(err_count));  // R3
  AST_FIRST_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> first_err_idx >= IDX_W'(STAGES));  // R3

endmodule

bind sr_upset_harness sr_upset_harness_chk #(
  .STAGES(STAGES), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .err_count(err_count), .err_flag(err_flag), .first_err_idx(first_err_idx)
);

// File: tb/sr_upset_harness_tb.sv
`timescale 1ns/1ps
module sr_upset_harness_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        upset_en = 1'b0;
  logic [3:0]  upset_sel = '0;
  logic [15:0] err_count;
  logic        err_flag;
  logic [31:0] first_err_idx;
  logic [15:0] alt_count;
  logic        alt_flag;
  logic [31:0] alt_first;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sr_upset_harness u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .upset_en(upset_en),
    .upset_sel(upset_sel), .err_count(err_count), .err_flag(err_flag),
    .first_err_idx(first_err_idx)
  );

  sr_upset_harness #(.STAGES(5), .INV_PER_GAP(0)) u_alt (
    .clk(clk), .rst_n(rst_n), .start(start), .upset_en(1'b0),
    .upset_sel(3'd0), .err_count(alt_count), .err_flag(alt_flag),
    .first_err_idx(alt_first)
  );

  // stage, injection edge after start, expected count, expected first index
  localparam int VEC [6][4] = '{
    '{0,  2,  1, 17},
    '{5,  10, 1, 20},
    '{7,  8,  1, 16},
    '{8,  8,  0, 0},
    '{15, 3,  0, 0},
    '{15, 20, 1, 20}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", err_count, 0);
    chk("R1 flag in reset", err_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", err_count, 0);
    chk("R1 first idx after reset", first_err_idx, 0);

    for (int v = 0; v < 6; v++) begin
      pulse_start();
      repeat (VEC[v][1] - 1) @(negedge clk);
      upset_sel = 4'(VEC[v][0]);
      upset_en  = 1'b1;
      @(negedge clk) upset_en = 1'b0;
      repeat (N + 4) @(negedge clk);
      chk($sformatf("R4 count vec%0d", v), err_count, VEC[v][2]);
      chk($sformatf("R5 first idx vec%0d", v), first_err_idx, VEC[v][3]);
      chk($sformatf("R6 flag vec%0d", v), err_flag, VEC[v][2] != 0);
    end

    // R5: a second flip in the same run keeps the first index
    pulse_start();
    repeat (19) @(negedge clk);
    upset_sel = 4'd15; upset_en = 1'b1;
    @(negedge clk) upset_en = 1'b0;
    repeat (9) @(negedge clk);
    upset_en = 1'b1;
    @(negedge clk) upset_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 count after two flips", err_count, 2);
    chk("R5 first idx kept", first_err_idx, 20);

    // R8: start clears results at its edge
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8 count cleared", err_count, 0);
    chk("R8 flag cleared", err_flag, 0);
    chk("R8 first idx cleared", first_err_idx, 0);

    // R2: long fault-free run, both parameter sets
    repeat (300) @(negedge clk);
    chk("R2 no errors even chain", err_count, 0);
    chk("R2 no errors odd chain", alt_count, 0);

    // R7: saturation with continuous injection on the last stage
    pulse_start();
    upset_sel = 4'd15; upset_en = 1'b1;
    repeat (66000) @(negedge clk);
    upset_en = 1'b0;
    @(negedge clk);
    chk("R7 saturated count", err_count, 65535);
    chk("R7 first idx", first_err_idx, 16);
    chk("R6 flag at saturation", err_flag, 1);
    chk("R2 odd chain untouched", alt_flag, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule